// File: doc/BRIEF.md
# Multi-Port GPIO Register Front-End

This block is the register side of a general-purpose I/O peripheral with up to four ports. A processor reaches it over a simple two-phase peripheral bus. It uses 32-bit reads and writes, with a setup phase and then an access phase. Each port holds an output value word and a drive-enable word, which go straight to the pad ring. The block also offers a synchronized view of the levels present on that port's input pins.

The same address space holds the configuration words for a separate interrupt-detection block: enable, mask, trigger type, polarity and a debounce-enable word for the first port. It also shows that block's status word and turns writes at an end-of-interrupt offset into a one-cycle clear pulse. A static strap input selects an alternate placement for the interrupt-related words, while the port words stay put. The synchronized first-port pins are also handed to the interrupt block.

Top module: `gpio_mmio_regs`

## Requirements
- R1: After reset every stored word is zero, so pin_out, pin_oe, all interrupt configuration outputs and eoi_pulse are zero, and every readable offset returns zero while inputs are zero.
- R2: Port p (p = 0..NPORTS-1) has an output value word at byte offset 12*p (0x00, 0x0C, 0x18, 0x24). A write stores the word, a read returns it, and it drives pin_out[p*PW +: PW] from the cycle after the write commits.
- R3: Port p has a direction word at byte offset 12*p+4 (0x04, 0x10, 0x1C, 0x28). It reads back as written and drives pin_oe[p*PW +: PW], where a 1 bit makes that pin an output and a 0 bit leaves it undriven.
- R4: Offset 0x50+4*p returns the level of port p's input pins through a two-flop synchronizer. A change on pin_in is not visible after one rising edge and is visible after the second.
- R5: With alt_map low, the interrupt words are: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, status 0x40 (returns irq_status), debounce enable 0x48, end-of-interrupt 0x4C. The stored words appear on irq_en, irq_mask, irq_type, irq_pol and deb_en.
- R6: With alt_map high, type is at 0x34, polarity at 0x38, status at 0x3C, end-of-interrupt at 0x40 and mask at 0x44. Enable stays at 0x30 and debounce stays at 0x48.
- R7: A write to the end-of-interrupt offset drives eoi_pulse with the written word for exactly the one cycle after the commit edge, and eoi_pulse is zero otherwise. The word is not stored, and reading that offset returns zero.
- R8: Offsets that map to nothing return zero and ignore writes. This includes 0x08/0x14/0x20/0x2C, anything at or above 0x60, 0x44 with alt_map low, 0x4C with alt_map high, and any offset whose two low bits are not zero.
- R9: Writes to the pin-level and status offsets change nothing; those offsets keep returning the synchronized pins and irq_status.
- R10: A word is written only when psel, penable and pwrite are all high at a rising edge. A setup phase alone, or a read, modifies nothing.
- R11: The strap changes only where the interrupt words are placed, not their contents: a word written through one map reads back through its offset in the other map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_map | input | 1 | Strap selecting the alternate interrupt-word placement |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 7 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| pin_in | input | NPORTS*PW | Raw input pin levels, port p in slice p |
| pin_out | output | NPORTS*PW | Output value per port |
| pin_oe | output | NPORTS*PW | Output enable per port |
| pin_sync_a | output | PW | Synchronized first-port pins for the interrupt block |
| irq_status | input | PW | Status word from the interrupt block |
| irq_en | output | PW | Interrupt enable word |
| irq_mask | output | PW | Interrupt mask word |
| irq_type | output | PW | Interrupt trigger type word |
| irq_pol | output | PW | Interrupt polarity word |
| deb_en | output | PW | Debounce enable word, first port only |
| eoi_pulse | output | PW | One-cycle end-of-interrupt clear vector |

## Verification
Stored words, pin_out, pin_oe and the configuration outputs change at the commit edge that ends the access phase. They are sampled at the falling edge after it. eoi_pulse is checked at that same falling edge, and again one cycle later for zero. Read data comes from combinational logic during the access phase and is sampled at the falling edge where penable rises. Pin levels need two rising edges, so the bench checks one read sampled after a single edge, which must return the old level. After any other pin change it waits two cycles before reading.

// File: rtl/gpio_regs_pkg.sv
`timescale 1ns/1ps
package gpio_regs_pkg;

  localparam int MAX_PORTS = 4;
  localparam int ADDR_W    = 7;

  typedef enum logic [3:0] {
    K_NONE, K_DATA, K_DIR, K_PINS,
    K_IEN, K_IMSK, K_ITYP, K_IPOL, K_ISTA, K_DEB, K_EOI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  port;
  } reg_sel_t;

  // Map a byte offset to a register kind and port number.
  function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] byte_addr,
                                             input logic alt_map,
                                             input int unsigned nports);
    reg_sel_t    s;
    logic [4:0]  w;
    int unsigned grp;
    int unsigned slot;
    s.kind = K_NONE;
    s.port = '0;
    w      = byte_addr[ADDR_W-1:2];
    if (byte_addr[1:0] == 2'b00) begin
      if (w < 5'd12) begin
        grp    = int'(w) / 3;
        slot   = int'(w) % 3;
        s.port = grp[1:0];
        if (grp < nports) begin
          if (slot == 0)      s.kind = K_DATA;
          else if (slot == 1) s.kind = K_DIR;
        end
      end else if (w >= 5'd20 && w < 5'd24) begin
        grp    = int'(w) - 20;
        s.port = grp[1:0];
        if (grp < nports) s.kind = K_PINS;
      end else if (w == 5'd12) begin
        s.kind = K_IEN;
      end else if (w == 5'd18) begin
        s.kind = K_DEB;
      end else if (!alt_map) begin
        case (w)
          5'd13:   s.kind = K_IMSK;
          5'd14:   s.kind = K_ITYP;
          5'd15:   s.kind = K_IPOL;
          5'd16:   s.kind = K_ISTA;
          5'd19:   s.kind = K_EOI;
          default: s.kind = K_NONE;
        endcase
      end else begin
        case (w)
          5'd17:   s.kind = K_IMSK;
          5'd13:   s.kind = K_ITYP;
          5'd14:   s.kind = K_IPOL;
          5'd15:   s.kind = K_ISTA;
          5'd16:   s.kind = K_EOI;
          default: s.kind = K_NONE;
        endcase
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;

  // Cycles since reset, saturating, so the two-deep look-back stays in range.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_two_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (q_out == $past(d_in, 2)));

endmodule

// File: rtl/gpio_port_bank.sv
`timescale 1ns/1ps
module gpio_port_bank #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data_en,
  input  logic          wr_dir_en,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] data_q,
  output logic [PW-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_en) data_q <= wdata;
      if (wr_dir_en)  dir_q  <= wdata;
    end
  end

  assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> (data_q == $past(wdata)));
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_en |=> $stable(data_q));
  assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> (dir_q == $past(wdata)));
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir_en |=> $stable(dir_q));

endmodule

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
module gpio_irq_cfg #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ien,
  input  logic          wr_imsk,
  input  logic          wr_ityp,
  input  logic          wr_ipol,
  input  logic          wr_deb,
  input  logic          wr_eoi,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] en_q,
  output logic [PW-1:0] msk_q,
  output logic [PW-1:0] typ_q,
  output logic [PW-1:0] pol_q,
  output logic [PW-1:0] deb_q,
  output logic [PW-1:0] eoi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
      typ_q <= '0;
      pol_q <= '0;
      deb_q <= '0;
      eoi_q <= '0;
    end else begin
      if (wr_ien)  en_q  <= wdata;
      if (wr_imsk) msk_q <= wdata;
      if (wr_ityp) typ_q <= wdata;
      if (wr_ipol) pol_q <= wdata;
      if (wr_deb)  deb_q <= wdata;
      eoi_q <= wr_eoi ? wdata : '0;
    end
  end

  wire cfg_wr_any = wr_ien | wr_imsk | wr_ityp | wr_ipol | wr_deb;

  assert_eoi_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_q != '0) |-> $past(wr_eoi));
  assert_eoi_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi |=> (eoi_q == $past(wdata)));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_any |=> ($stable(en_q) && $stable(msk_q) && $stable(typ_q)
                     && $stable(pol_q) && $stable(deb_q)));
  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_imsk |=> (msk_q == $past(wdata)));

endmodule

// File: rtl/gpio_mmio_regs.sv
`timescale 1ns/1ps
module gpio_mmio_regs
  import gpio_regs_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PW     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alt_map,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic [NPORTS*PW-1:0] pin_in,
  output logic [NPORTS*PW-1:0] pin_out,
  output logic [NPORTS*PW-1:0] pin_oe,
  output logic [PW-1:0]        pin_sync_a,
  input  logic [PW-1:0]        irq_status,
  output logic [PW-1:0]        irq_en,
  output logic [PW-1:0]        irq_mask,
  output logic [PW-1:0]        irq_type,
  output logic [PW-1:0]        irq_pol,
  output logic [PW-1:0]        deb_en,
  output logic [PW-1:0]        eoi_pulse
);

  localparam int BUS_W = NPORTS * PW;

  // Decode is shared by reads and writes; the strap acts immediately.
  reg_sel_t sel;
  assign sel = decode_offset(paddr, alt_map, NPORTS);

  wire            wr_fire = psel & penable & pwrite;
  wire [PW-1:0]   wword   = pwdata[PW-1:0];

  logic [MAX_PORTS-1:0] wr_data_v;
  logic [MAX_PORTS-1:0] wr_dir_v;
  logic wr_ien, wr_imsk, wr_ityp, wr_ipol, wr_deb, wr_eoi;

  always_comb begin
    wr_data_v = '0;
    wr_dir_v  = '0;
    if (wr_fire && sel.kind == K_DATA) wr_data_v[sel.port] = 1'b1;
    if (wr_fire && sel.kind == K_DIR)  wr_dir_v[sel.port]  = 1'b1;
    wr_ien  = wr_fire && (sel.kind == K_IEN);
    wr_imsk = wr_fire && (sel.kind == K_IMSK);
    wr_ityp = wr_fire && (sel.kind == K_ITYP);
    wr_ipol = wr_fire && (sel.kind == K_IPOL);
    wr_deb  = wr_fire && (sel.kind == K_DEB);
    wr_eoi  = wr_fire && (sel.kind == K_EOI);
  end

  logic [BUS_W-1:0] pins_sync;

  gpio_in_sync #(.W(BUS_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .q_out (pins_sync)
  );

  logic [PW-1:0] data_arr [MAX_PORTS];
  logic [PW-1:0] dir_arr  [MAX_PORTS];
  logic [PW-1:0] pins_arr [MAX_PORTS];

  for (genvar gp = 0; gp < MAX_PORTS; gp++) begin : g_port
    if (gp < NPORTS) begin : g_on
      gpio_port_bank #(.PW(PW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_v[gp]),
        .wr_dir_en  (wr_dir_v[gp]),
        .wdata      (wword),
        .data_q     (data_arr[gp]),
        .dir_q      (dir_arr[gp])
      );
      assign pin_out[gp*PW +: PW] = data_arr[gp];
      assign pin_oe[gp*PW +: PW]  = dir_arr[gp];
      assign pins_arr[gp]         = pins_sync[gp*PW +: PW];
    end else begin : g_off
      assign data_arr[gp] = '0;
      assign dir_arr[gp]  = '0;
      assign pins_arr[gp] = '0;
    end
  end

  assign pin_sync_a = pins_arr[0];

  gpio_irq_cfg #(.PW(PW)) u_irq_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ien  (wr_ien),
    .wr_imsk (wr_imsk),
    .wr_ityp (wr_ityp),
    .wr_ipol (wr_ipol),
    .wr_deb  (wr_deb),
    .wr_eoi  (wr_eoi),
    .wdata   (wword),
    .en_q    (irq_en),
    .msk_q   (irq_mask),
    .typ_q   (irq_type),
    .pol_q   (irq_pol),
    .deb_q   (deb_en),
    .eoi_q   (eoi_pulse)
  );

  logic [PW-1:0] rd_word;

  always_comb begin
    case (sel.kind)
      K_DATA:  rd_word = data_arr[sel.port];
      K_DIR:   rd_word = dir_arr[sel.port];
      K_PINS:  rd_word = pins_arr[sel.port];
      K_IEN:   rd_word = irq_en;
      K_IMSK:  rd_word = irq_mask;
      K_ITYP:  rd_word = irq_type;
      K_IPOL:  rd_word = irq_pol;
      K_ISTA:  rd_word = irq_status;
      K_DEB:   rd_word = deb_en;
      default: rd_word = '0;
    endcase
  end

  assign prdata = psel ? 32'(rd_word) : 32'd0;

  wire [2*MAX_PORTS+5:0] wr_strobes = {wr_data_v, wr_dir_v, wr_ien, wr_imsk,
                                       wr_ityp, wr_ipol, wr_deb, wr_eoi};

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobes));
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && sel.kind == K_NONE) |-> (prdata == 32'd0));
  assert_no_write_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(irq_en)
                            && $stable(irq_mask) && $stable(deb_en)));

endmodule

// File: tb/gpio_mmio_regs_tb.sv
`timescale 1ns/1ps
module gpio_mmio_regs_tb;

  localparam int NP = 4;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alt_map = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic [NP*PW-1:0] pin_in = '0;
  logic [NP*PW-1:0] pin_out, pin_oe;
  logic [PW-1:0] pin_sync_a, irq_status = '0;
  logic [PW-1:0] irq_en, irq_mask, irq_type, irq_pol, deb_en, eoi_pulse;

  always #4 clk = ~clk;

  gpio_mmio_regs #(.NPORTS(NP), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .alt_map(alt_map), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_sync_a(pin_sync_a),
    .irq_status(irq_status), .irq_en(irq_en), .irq_mask(irq_mask),
    .irq_type(irq_type), .irq_pol(irq_pol), .deb_en(deb_en), .eoi_pulse(eoi_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [31:0] m_data [NP];
  bit [31:0] m_dir  [NP];
  bit [31:0] m_en, m_msk, m_typ, m_pol, m_deb;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Codes: 0 none, 1 data, 2 dir, 3 pins, 4 en, 5 mask, 6 type, 7 pol, 8 status, 9 debounce, 10 eoi
  function automatic int bench_code(input int a, input bit alt, output int p);
    p = 0;
    for (int i = 0; i < NP; i++) begin
      if (a == i*12)     begin p = i; return 1; end
      if (a == i*12 + 4) begin p = i; return 2; end
      if (a == 80 + i*4) begin p = i; return 3; end
    end
    if (a == 'h30) return 4;
    if (a == 'h48) return 9;
    if (alt) begin
      if (a == 'h44) return 5;
      if (a == 'h34) return 6;
      if (a == 'h38) return 7;
      if (a == 'h3C) return 8;
      if (a == 'h40) return 10;
    end else begin
      if (a == 'h34) return 5;
      if (a == 'h38) return 6;
      if (a == 'h3C) return 7;
      if (a == 'h40) return 8;
      if (a == 'h4C) return 10;
    end
    return 0;
  endfunction

  function automatic string tag_of(input int c, input bit alt);
    case (c)
      0: return "R8";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      8: return "R9";
      10: return "R7";
      default: return alt ? "R6" : "R5";
    endcase
  endfunction

  function automatic bit [31:0] exp_read(input int a, input bit alt);
    int p, c;
    c = bench_code(a, alt, p);
    case (c)
      1: return m_data[p];
      2: return m_dir[p];
      3: return pin_in[p*PW +: PW];
      4: return m_en;
      5: return m_msk;
      6: return m_typ;
      7: return m_pol;
      8: return irq_status;
      9: return m_deb;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_outputs(input string req);
    for (int i = 0; i < NP; i++) begin
      chk(pin_out[i*PW +: PW] == m_data[i], req, pin_out[i*PW +: PW], m_data[i]);
      chk(pin_oe[i*PW +: PW] == m_dir[i], req, pin_oe[i*PW +: PW], m_dir[i]);
    end
    chk(irq_en == m_en, req, irq_en, m_en);
    chk(irq_mask == m_msk, req, irq_mask, m_msk);
    chk(irq_type == m_typ, req, irq_type, m_typ);
    chk(irq_pol == m_pol, req, irq_pol, m_pol);
    chk(deb_en == m_deb, req, deb_en, m_deb);
  endtask

  task automatic apb_write(input int a, input bit [31:0] d);
    int p, c;
    bit [31:0] eoi_exp;
    c = bench_code(a, alt_map, p);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 7'(a); pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    eoi_exp = 0;
    case (c)
      1: m_data[p] = d;
      2: m_dir[p] = d;
      4: m_en = d;
      5: m_msk = d;
      6: m_typ = d;
      7: m_pol = d;
      9: m_deb = d;
      10: eoi_exp = d;
      default: ;
    endcase
    chk(eoi_pulse == eoi_exp, "R7", eoi_pulse, eoi_exp);
    check_outputs(tag_of(c, alt_map));
    @(negedge clk);
    chk(eoi_pulse == 32'd0, "R7", eoi_pulse, 32'd0);
  endtask

  task automatic apb_read(input int a);
    int p, c;
    bit [31:0] e;
    c = bench_code(a, alt_map, p);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 7'(a);
    @(negedge clk); penable = 1;
    #1;
    e = exp_read(a, alt_map);
    chk(prdata == e, tag_of(c, alt_map), prdata, e);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 'h60; a += 4) apb_read(a);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) begin m_data[i] = 0; m_dir[i] = 0; end
    m_en = 0; m_msk = 0; m_typ = 0; m_pol = 0; m_deb = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports and through reads
    check_outputs("R1");
    chk(eoi_pulse == 0, "R1", eoi_pulse, 0);
    for (int a = 0; a < 'h60; a += 4) begin
      @(negedge clk); psel = 1; paddr = 7'(a); @(negedge clk); penable = 1; #1;
      chk(prdata == 0, "R1", prdata, 0);
      @(negedge clk); psel = 0; penable = 0;
    end
    // R2 / R3: port words with distinct patterns
    for (int i = 0; i < NP; i++) begin
      apb_write(i*12, 32'hA5000000 | i);
      apb_write(i*12 + 4, 32'h0F0F0000 ^ (i << 8));
    end
    for (int i = 0; i < NP; i++) begin apb_read(i*12); apb_read(i*12 + 4); end
    apb_write(4, 32'hFFFFFFFF);
    apb_write(4, 32'h00000000);
    // R5: default interrupt map
    irq_status = 32'h1234ABCD;
    apb_write('h30, 32'h11111111);
    apb_write('h34, 32'h22222222);
    apb_write('h38, 32'h33333333);
    apb_write('h3C, 32'h44444444);
    apb_write('h48, 32'h55555555);
    for (int a = 'h30; a <= 'h4C; a += 4) apb_read(a);
    apb_write('h4C, 32'hC0FFEE01);                // R7 default placement
    apb_read('h4C);
    apb_write('h44, 32'hDEADBEEF);                // R8 unmapped in default map
    // R6 / R11: alternate map sees the same storage at new places
    @(negedge clk); alt_map = 1;
    for (int a = 'h30; a <= 'h4C; a += 4) apb_read(a);
    apb_write('h44, 32'h66666666);
    apb_write('h34, 32'h77777777);
    apb_write('h38, 32'h88888888);
    apb_write('h40, 32'h0000F00D);                // R7 alternate placement
    apb_write('h4C, 32'hBAD0BAD0);                // R8 unmapped in alternate map
    for (int a = 'h30; a <= 'h4C; a += 4) apb_read(a);
    @(negedge clk); alt_map = 0;
    apb_read('h34); apb_read('h38); apb_read('h3C);   // R11 back in default map
    // R8: holes, high offsets, misaligned
    apb_write('h08, 32'hFFFFFFFF); apb_write('h2C, 32'hFFFFFFFF);
    apb_write('h60, 32'hFFFFFFFF); apb_write('h7C, 32'hFFFFFFFF);
    apb_write('h01, 32'hFFFFFFFF); apb_write('h32, 32'hFFFFFFFF);
    apb_read('h08); apb_read('h64); apb_read('h01);
    read_all();
    // R9: read-only offsets ignore writes
    pin_in = {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210};
    repeat (3) @(negedge clk);
    apb_write('h50, 32'h0); apb_write('h5C, 32'h0); apb_write('h40, 32'h0);
    apb_read('h50); apb_read('h5C); apb_read('h40);
    read_all();
    // R10: setup phase only, then a read, must modify nothing
    @(negedge clk); psel = 1; pwrite = 1; paddr = 7'h00; pwdata = 32'hFFFF0000;
    @(negedge clk); psel = 0; pwrite = 0;
    @(negedge clk);
    check_outputs("R10");
    apb_read('h00);
    // R4: pin change visible after two edges, not one
    @(negedge clk); pin_in[PW-1:0] = 32'hCAFED00D;
    psel = 1; pwrite = 0; paddr = 7'h50;
    @(negedge clk); penable = 1; #1;
    chk(prdata == 32'h76543210, "R4", prdata, 32'h76543210);
    @(negedge clk); psel = 0; penable = 0;
    apb_read('h50);
    chk(pin_sync_a == 32'hCAFED00D, "R4", pin_sync_a, 32'hCAFED00D);
    // Random mix
    for (int n = 0; n < 500; n++) begin
      int a, op;
      op = int'($urandom_range(0, 15));
      a = int'($urandom_range(0, 127));
      if (op != 0) a = a & ~3;
      if (op == 1) begin
        @(negedge clk); pin_in = {$urandom, $urandom, $urandom, $urandom};
        repeat (2) @(negedge clk);
      end else if (op == 2) begin
        @(negedge clk); alt_map = $urandom_range(0, 1) == 1;
        irq_status = $urandom;
      end else if (op < 9) begin
        apb_write(a, $urandom);
      end else begin
        apb_read(a);
      end
    end
    read_all();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule